// File: doc/BRIEF.md
# Software Interrupt Acceptance Filter

This block decides whether a software-generated interrupt request may mark its target interrupt as pending. A request names an interrupt ID, the group the sender asks for, and whether the sender is non-secure. The block compares the request with the group configured for that ID and, when the non-secure check applies, with the 2-bit access level software has granted for it. Every decision is registered, so the outcome appears at the outputs one clock after the request.

The configured group of each ID comes from two per-ID bits: a group bit and a modifier bit. A global security-disable input turns off the secure/non-secure distinction. When the request is accepted, the block pulses one set-pending bit for the ID. The pending storage is outside the block and consumes that pulse. Routing requests between processors is also outside the block.

Top module: `sgi_accept_filter`

## Requirements
- R1: After reset, and until the first request arrives, `accept_o`, `reject_o` and `set_pend_o` are all zero.
- R2: The configured group of ID n is derived from `cfg_grp_i[n]` and `cfg_mod_i[n]`. Group bit 0 gives Group 0. Group bit 1 with modifier 0 gives Non-secure Group 1. Group bit 1 with modifier 1 gives Secure Group 1 while security is enabled (`sec_dis_i`=0); while security is disabled the modifier is ignored and the result is Non-secure Group 1.
- R3: The request group `req_grp_i` is encoded as 0 = Group 0, 1 = Non-secure Group 1, 2 = Secure Group 1, 3 = reserved. A Secure Group 1 request aimed at a Group 0 interrupt is handled exactly as a Group 0 request, including the access-level check.
- R4: After the adjustment in R3, a request is rejected when its group differs from the configured group. A reserved group code is always rejected.
- R5: A request with an ID of 16 or more is rejected and sets no pending bit.
- R6: The access level of ID n is `ns_acc_i[2n+1:2n]`. A non-secure request to a Group 0 interrupt while security is enabled needs a level of 1 or more.
- R7: A non-secure request to a Secure Group 1 interrupt while security is enabled needs a level of 2 or more.
- R8: The access level is not consulted for secure requests, while security is disabled, or for Non-secure Group 1 interrupts.
- R9: An accepted request raises `accept_o` and bit ID of `set_pend_o` in the cycle after the request. All other bits of `set_pend_o` stay zero.
- R10: Each valid request produces exactly one of `accept_o` or `reject_o`, each lasting one cycle, in the following cycle. With no valid request, both outputs and `set_pend_o` are zero in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_id_i | input | 5 | Target interrupt ID |
| req_grp_i | input | 2 | Requested group (0 G0, 1 NS G1, 2 S G1, 3 reserved) |
| req_ns_i | input | 1 | Request comes from a non-secure sender |
| cfg_grp_i | input | 16 | Per-ID group bit |
| cfg_mod_i | input | 16 | Per-ID group modifier bit |
| ns_acc_i | input | 32 | Per-ID 2-bit non-secure access level |
| sec_dis_i | input | 1 | Security disabled |
| accept_o | output | 1 | Request accepted (one-cycle pulse) |
| reject_o | output | 1 | Request rejected (one-cycle pulse) |
| set_pend_o | output | 16 | One-hot set-pending pulse for the accepted ID |

## Verification
A wrong configured-group decode or a wrong access-level field select flips the accept/reject outcome for a particular ID. That error is visible one clock after the request that exposes it. A wrong ID-to-bit mapping shows as a set-pending pulse on the wrong bit in the same cycle as `accept_o`. Any state left over from an earlier decision appears as a pulse in a cycle with no request. The directed cases therefore place each configuration on distinct IDs and check the cycle after every request, as well as idle cycles.

// File: rtl/sgi_filter_pkg.sv
package sgi_filter_pkg;
  typedef enum logic [1:0] {
    GRP_0    = 2'd0,
    GRP_1NS  = 2'd1,
    GRP_1S   = 2'd2,
    GRP_RSVD = 2'd3
  } grp_e;

  localparam int unsigned LVL_W       = 2;
  localparam int unsigned LVL_G0_MIN  = 1;
  localparam int unsigned LVL_G1S_MIN = 2;
endpackage

// File: rtl/sgi_cfg_group.sv
module sgi_cfg_group
  import sgi_filter_pkg::*;
#(
  parameter int unsigned NUM_ID = 16,
  localparam int unsigned IDX_W = $clog2(NUM_ID)
) (
  input  logic [NUM_ID-1:0] grp_bits_i,
  input  logic [NUM_ID-1:0] mod_bits_i,
  input  logic              sec_dis_i,
  input  logic [IDX_W-1:0]  idx_i,
  output grp_e              grp_o
);
  grp_e per_id [NUM_ID];

  for (genvar g = 0; g < NUM_ID; g++) begin : g_dec
    always_comb begin
      if (!grp_bits_i[g])                    per_id[g] = GRP_0;
      else if (mod_bits_i[g] && !sec_dis_i)  per_id[g] = GRP_1S;
      else                                   per_id[g] = GRP_1NS;
    end
  end

  assign grp_o = per_id[idx_i];
endmodule

// File: rtl/sgi_ns_level.sv
module sgi_ns_level
  import sgi_filter_pkg::*;
#(
  parameter int unsigned NUM_ID = 16,
  localparam int unsigned IDX_W = $clog2(NUM_ID)
) (
  input  logic [LVL_W*NUM_ID-1:0] acc_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [LVL_W-1:0]        lvl_o
);
  logic [LVL_W-1:0] lvl [NUM_ID];

  for (genvar g = 0; g < NUM_ID; g++) begin : g_fld
    assign lvl[g] = acc_i[LVL_W*g +: LVL_W];
  end

  assign lvl_o = lvl[idx_i];
endmodule

// File: rtl/sgi_accept_rule.sv
module sgi_accept_rule
  import sgi_filter_pkg::*;
(
  input  grp_e             req_grp_i,
  input  grp_e             cfg_grp_i,
  input  logic             req_ns_i,
  input  logic             sec_dis_i,
  input  logic             id_ok_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             accept_o
);
  grp_e             eff_grp;
  logic             grp_match;
  logic             lvl_chk;
  logic [LVL_W-1:0] lvl_need;
  logic             lvl_ok;

  // secure G1 request on a G0 interrupt is downgraded to G0
  assign eff_grp   = (req_grp_i == GRP_1S && cfg_grp_i == GRP_0) ? GRP_0 : req_grp_i;
  assign grp_match = (req_grp_i != GRP_RSVD) && (eff_grp == cfg_grp_i);
  assign lvl_chk   = req_ns_i && !sec_dis_i;

  always_comb begin
    unique case (cfg_grp_i)
      GRP_0:   lvl_need = LVL_W'(LVL_G0_MIN);
      GRP_1S:  lvl_need = LVL_W'(LVL_G1S_MIN);
      default: lvl_need = '0;
    endcase
  end

  assign lvl_ok   = !lvl_chk || (lvl_i >= lvl_need);
  assign accept_o = id_ok_i && grp_match && lvl_ok;
endmodule

// File: rtl/sgi_accept_filter.sv
module sgi_accept_filter
  import sgi_filter_pkg::*;
#(
  parameter int unsigned NUM_ID = 16,
  parameter int unsigned ID_W   = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [ID_W-1:0]         req_id_i,
  input  logic [1:0]              req_grp_i,
  input  logic                    req_ns_i,
  input  logic [NUM_ID-1:0]       cfg_grp_i,
  input  logic [NUM_ID-1:0]       cfg_mod_i,
  input  logic [LVL_W*NUM_ID-1:0] ns_acc_i,
  input  logic                    sec_dis_i,
  output logic                    accept_o,
  output logic                    reject_o,
  output logic [NUM_ID-1:0]       set_pend_o
);
  localparam int unsigned IDX_W = $clog2(NUM_ID);

  logic [IDX_W-1:0] idx;
  logic             id_ok;
  grp_e             cfg_grp;
  logic [LVL_W-1:0] lvl;
  logic             acc_d;
  logic [NUM_ID-1:0] pend_d;

  assign idx   = req_id_i[IDX_W-1:0];
  assign id_ok = ({{(32-ID_W){1'b0}}, req_id_i} < NUM_ID);

  sgi_cfg_group #(.NUM_ID(NUM_ID)) i_cfg_group (
    .grp_bits_i (cfg_grp_i),
    .mod_bits_i (cfg_mod_i),
    .sec_dis_i  (sec_dis_i),
    .idx_i      (idx),
    .grp_o      (cfg_grp)
  );

  sgi_ns_level #(.NUM_ID(NUM_ID)) i_ns_level (
    .acc_i (ns_acc_i),
    .idx_i (idx),
    .lvl_o (lvl)
  );

  sgi_accept_rule i_accept_rule (
    .req_grp_i (grp_e'(req_grp_i)),
    .cfg_grp_i (cfg_grp),
    .req_ns_i  (req_ns_i),
    .sec_dis_i (sec_dis_i),
    .id_ok_i   (id_ok),
    .lvl_i     (lvl),
    .accept_o  (acc_d)
  );

  always_comb begin
    pend_d = '0;
    if (req_valid_i && acc_d) pend_d[idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o   <= 1'b0;
      reject_o   <= 1'b0;
      set_pend_o <= '0;
    end else begin
      accept_o   <= req_valid_i && acc_d;
      reject_o   <= req_valid_i && !acc_d;
      set_pend_o <= pend_d;
    end
  end
endmodule

// File: rtl/sgi_accept_filter_chk.sv
module sgi_accept_filter_chk
  import sgi_filter_pkg::*;
#(
  parameter int unsigned NUM_ID = 16,
  parameter int unsigned ID_W   = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic [ID_W-1:0]         req_id_i,
  input logic [1:0]              req_grp_i,
  input logic                    accept_o,
  input logic                    reject_o,
  input logic [NUM_ID-1:0]       set_pend_o
);
  localparam logic [NUM_ID-1:0] ONE = NUM_ID'(1);

  // R9
  pend_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_pend_o));

  // R9
  pend_matches_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && ({{(32-ID_W){1'b0}}, req_id_i} < NUM_ID) |=>
      (accept_o ? (set_pend_o == (ONE << $past(req_id_i))) : (set_pend_o == '0)));

  // R10
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (accept_o ^ reject_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!accept_o && !reject_o && set_pend_o == '0));

  // R5
  id_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && ({{(32-ID_W){1'b0}}, req_id_i} >= NUM_ID) |=> (reject_o && set_pend_o == '0));

  // R4
  rsvd_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_grp_i == 2'd3 |=> reject_o);
endmodule

bind sgi_accept_filter sgi_accept_filter_chk #(.NUM_ID(NUM_ID), .ID_W(ID_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_id_i    (req_id_i),
  .req_grp_i   (req_grp_i),
  .accept_o    (accept_o),
  .reject_o    (reject_o),
  .set_pend_o  (set_pend_o)
);

// File: tb/test_sgi_accept_filter.sv
module test_sgi_accept_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [4:0]  req_id_i = '0;
  logic [1:0]  req_grp_i = '0;
  logic        req_ns_i = 1'b0;
  logic [15:0] cfg_grp_i = '0;
  logic [15:0] cfg_mod_i = '0;
  logic [31:0] ns_acc_i = '0;
  logic        sec_dis_i = 1'b0;
  logic        accept_o, reject_o;
  logic [15:0] set_pend_o;

  int vec = 0, bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  sgi_accept_filter i_sgi_accept_filter (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request at negedge, check outputs at the following negedge
  task automatic send(int id, int grp, bit ns, bit exp_acc, string tag);
    logic [15:0] exp_p;
    exp_p = (exp_acc && id < 16) ? (16'h1 << id) : 16'h0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_id_i = 5'(id); req_grp_i = 2'(grp); req_ns_i = ns;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({tag, " accept"}, {31'b0, accept_o}, {31'b0, exp_acc});
    chk({tag, " reject"}, {31'b0, reject_o}, {31'b0, !exp_acc});
    chk({tag, " set_pend"}, {16'b0, set_pend_o}, {16'b0, exp_p});
  endtask

  task automatic t_reset();
    chk("R1 accept", {31'b0, accept_o}, 0);
    chk("R1 reject", {31'b0, reject_o}, 0);
    chk("R1 set_pend", {16'b0, set_pend_o}, 0);
  endtask

  task automatic t_decode();
    cfg_grp_i = 16'h0008; cfg_mod_i = 16'h0008; sec_dis_i = 0; ns_acc_i = '0;
    send(3, 2, 0, 1, "R2 sg1 cfg sec req");
    send(3, 1, 0, 0, "R2 sg1 cfg ns-g1 req");
    cfg_mod_i = 16'h0000;
    send(3, 1, 0, 1, "R2 nsg1 cfg");
    send(3, 2, 0, 0, "R2 nsg1 cfg sg1 req");
    cfg_mod_i = 16'h0008; sec_dis_i = 1;
    send(3, 1, 1, 1, "R2 secdis mod ignored");
    send(3, 2, 0, 0, "R2 secdis no sg1");
    sec_dis_i = 0;
  endtask

  task automatic t_promote();
    cfg_grp_i = 16'h0000; cfg_mod_i = 16'h0000; ns_acc_i = '0;
    send(5, 2, 0, 1, "R3 sg1 to g0 secure");
    send(5, 2, 1, 0, "R3 promoted ns lvl0");
    ns_acc_i[11:10] = 2'd1;
    send(5, 2, 1, 1, "R3 promoted ns lvl1");
  endtask

  task automatic t_mismatch();
    cfg_grp_i = 16'h0000; ns_acc_i = '1;
    send(9, 1, 0, 0, "R4 nsg1 on g0");
    send(9, 3, 0, 0, "R4 reserved grp");
    cfg_grp_i = 16'h0200;
    send(9, 0, 0, 0, "R4 g0 on nsg1");
  endtask

  task automatic t_range();
    cfg_grp_i = '0; ns_acc_i = '1;
    send(16, 0, 0, 0, "R5 id16");
    send(31, 0, 0, 0, "R5 id31");
    send(15, 0, 0, 1, "R5 id15 ok");
  endtask

  task automatic t_level_g0();
    cfg_grp_i = '0; cfg_mod_i = '0; ns_acc_i = '0;
    send(7, 0, 1, 0, "R6 lvl0");
    ns_acc_i = 32'h0000_4000;  // level 1 on id 7 field [15:14]
    send(7, 0, 1, 1, "R6 lvl1");
    send(6, 0, 1, 0, "R6 neighbour field");
    ns_acc_i = 32'h0000_1000;  // level 1 on id 6 only
    send(7, 0, 1, 0, "R6 other id lvl");
    ns_acc_i = 32'h0000_C000;
    send(7, 0, 1, 1, "R6 lvl3");
  endtask

  task automatic t_level_g1s();
    cfg_grp_i = 16'h8000; cfg_mod_i = 16'h8000; ns_acc_i = 32'h4000_0000;
    send(15, 2, 1, 0, "R7 lvl1");
    ns_acc_i = 32'h8000_0000;
    send(15, 2, 1, 1, "R7 lvl2");
  endtask

  task automatic t_bypass();
    cfg_grp_i = '0; cfg_mod_i = '0; ns_acc_i = '0; sec_dis_i = 0;
    send(2, 0, 0, 1, "R8 secure req");
    sec_dis_i = 1;
    send(2, 0, 1, 1, "R8 secdis ns req");
    sec_dis_i = 0; cfg_grp_i = 16'h0010;
    send(4, 1, 1, 1, "R8 nsg1 ns req");
  endtask

  task automatic t_idle();
    cfg_grp_i = '0; ns_acc_i = '1;
    send(0, 0, 0, 1, "R10 pulse");
    @(negedge clk_i);
    chk("R10 pulse ends accept", {31'b0, accept_o}, 0);
    chk("R10 pulse ends pend", {16'b0, set_pend_o}, 0);
    repeat (3) @(negedge clk_i);
    chk("R10 idle reject", {31'b0, reject_o}, 0);
    send(1, 3, 0, 0, "R10 reject pulse");
    @(negedge clk_i);
    chk("R10 reject ends", {31'b0, reject_o}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_decode();
    t_promote();
    t_mismatch();
    t_range();
    t_level_g0();
    t_level_g1s();
    t_bypass();
    t_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule